// File: doc/BRIEF.md
# MIDI Serial Port with Command/Status Interface

This block connects a host processor to a MIDI serial line. It occupies two neighbouring host addresses. Address 0 is the data port and address 1 is the command/status port. Writing to the data port queues a byte for transmission. Reading it pops the oldest received byte. Writing to the command port changes the operating state. Reading it returns two FIFO flags.

Each direction has a 16-entry FIFO. The transmit side sends bytes at a fixed 31.25 kbaud. The receive side oversamples the input line at sixteen times the bit rate. A level interrupt follows the occupancy of the receive FIFO against a selectable threshold.

After reset, the port is in a command state. Here, data-port writes and incoming serial bytes are ignored. A reset command empties both queues and leaves an acknowledge byte for the host. A UART-mode command then opens the data path.

Top module: `midi_uart_port`

## Requirements
- R1: Each transmitted byte is framed on `midi_out` as one low start bit, eight data bits with the least significant first, and one high stop bit. Every bit lasts CLK_HZ/BAUD clock cycles, and the line idles high.
- R2: Bytes written to the data port (`bus_addr`=0) in UART mode are sent in the order written, one frame after another.
- R3: A well-formed serial frame on `midi_in` is stored in the receive FIFO. Data-port reads return the stored bytes oldest first.
- R4: A status read (`bus_addr`=1) returns the following bits. Bit 7 is 1 when the receive FIFO is empty and 0 when it holds data. Bit 6 is 1 when the transmit FIFO is full and 0 when it can accept a byte. Bits 5..0 are 0.
- R5: `irq` is 1 exactly while the receive FIFO holds at least the trigger count. `trig_sel` picks the count: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14. `irq` drops as soon as a read brings occupancy below that count.
- R6: A command write of FFh does the following. It empties both FIFOs and aborts any frame in progress, so `midi_out` returns high. It places the byte FEh in the receive FIFO and leaves UART mode.
- R7: A command write of 3Fh enters UART mode. Outside UART mode, data-port writes transmit nothing and received frames are not stored, but data-port reads still pop.
- R8: Any command value other than FFh and 3Fh changes neither the mode nor either FIFO.
- R9: A frame whose stop bit samples low is discarded. The receiver then waits for the line to return high before looking for a new start bit.
- R10: A byte that completes while the receive FIFO holds 16 entries is dropped, and the 16 stored bytes are kept intact.
- R11: A low pulse on `midi_in` shorter than half a bit is not taken as a start bit and stores nothing.
- R12: A data-port read while the receive FIFO is empty returns 00h and changes nothing.
- R13: After reset, `midi_out` is high, `irq` is low, both FIFOs are empty and the port is outside UART mode, so status reads 80h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of CLK_HZ |
| rst | input | 1 | Synchronous active-high reset |
| bus_cs | input | 1 | Host access strobe, one cycle per access |
| bus_wr | input | 1 | Access is a write |
| bus_rd | input | 1 | Access is a read |
| bus_addr | input | 1 | 0 = data port, 1 = command/status port |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after a read |
| trig_sel | input | 2 | Receive interrupt threshold select |
| midi_in | input | 1 | Serial input line |
| midi_out | output | 1 | Serial output line |
| irq | output | 1 | Receive threshold interrupt, level |

## Verification
The transmit path is tested with a single byte and with a burst of contrasting byte values (01h, 80h, 3Ch). These separate a bit-order swap or a FIFO reordering from a correct serializer. The receive path is tested with several stimuli:
- clean frames;
- a frame with a low stop bit followed by a good frame, which shows whether the receiver recovers after the framing error;
- a short low glitch;
- seventeen back-to-back frames against a full FIFO.

The interrupt threshold is probed on both sides of the 4 and 14 levels. Mode handling is checked by sending data before UART mode is entered, after an FFh reset and after an unrelated command. Each of these shows whether bytes leak through or the acknowledge byte is missing.

// File: rtl/midi_pkg.sv
package midi_pkg;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] CMD_UART  = 8'h3F;
  localparam logic [7:0] ACK_BYTE  = 8'hFE;
  localparam int STAT_RX_EMPTY = 7;
  localparam int STAT_TX_FULL  = 6;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_BREAK
  } rx_state_t;

  // receive interrupt threshold, clamped to the FIFO depth
  function automatic int unsigned trig_level(input logic [1:0] sel, input int unsigned depth);
    int unsigned lvl;
    case (sel)
      2'b00:   lvl = 1;
      2'b01:   lvl = 4;
      2'b10:   lvl = 8;
      default: lvl = 14;
    endcase
    return (lvl > depth) ? depth : lvl;
  endfunction
endpackage

// File: rtl/midi_tick_gen.sv
module midi_tick_gen #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/midi_fifo.sv
module midi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full && !clr;
  assign do_pop  = pop && !empty && !clr;
  assign dout    = mem[rd_ptr];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= nxt(wr_ptr);
      if (do_pop)  rd_ptr <= nxt(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !clr) |=> (count == $past(count)));
  assert_no_underflow_R12: assert property (@(posedge clk) disable iff (rst)
    (empty && pop && !push && !clr) |=> (count == '0));
endmodule

// File: rtl/midi_tx.sv
module midi_tx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       abort,
  input  logic       tick,
  input  logic       have_data,
  input  logic [7:0] data,
  output logic       take,
  output logic       line
);
  localparam int OCW = $clog2(OVS);
  logic           busy;
  logic [OCW-1:0] tcnt;
  logic [3:0]     bitn;
  logic [8:0]     shreg;

  assign take = !busy && have_data && !abort;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      busy  <= 1'b0;
      line  <= 1'b1;
      tcnt  <= '0;
      bitn  <= '0;
      shreg <= '1;
    end else if (!busy) begin
      if (have_data) begin
        busy  <= 1'b1;
        line  <= 1'b0;
        shreg <= {1'b1, data};
        tcnt  <= '0;
        bitn  <= '0;
      end
    end else if (tick) begin
      if (tcnt == OCW'(OVS - 1)) begin
        tcnt <= '0;
        if (bitn == 4'd9) begin
          busy <= 1'b0;
        end else begin
          line  <= shreg[0];
          shreg <= {1'b1, shreg[8:1]};
          bitn  <= bitn + 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> line);
endmodule

// File: rtl/midi_rx.sv
module midi_rx #(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       line_in,
  output logic       valid,
  output logic [7:0] data
);
  import midi_pkg::*;
  localparam int OCW = $clog2(OVS);

  rx_state_t      st;
  logic [1:0]     sync;
  logic           s;
  logic [OCW-1:0] cnt;
  logic [2:0]     bitn;
  logic [7:0]     shreg;

  assign s = sync[1];

  always_ff @(posedge clk) begin
    if (rst) sync <= 2'b11;
    else     sync <= {sync[0], line_in};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= RX_IDLE;
      cnt   <= '0;
      bitn  <= '0;
      shreg <= '0;
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= 1'b0;
      if (tick) begin
        case (st)
          RX_IDLE: if (!s) begin
            st  <= RX_START;
            cnt <= '0;
          end
          RX_START: begin
            if (cnt == OCW'(OVS/2 - 1)) begin
              cnt  <= '0;
              bitn <= '0;
              st   <= s ? RX_IDLE : RX_DATA;
            end else cnt <= cnt + 1'b1;
          end
          RX_DATA: begin
            if (cnt == OCW'(OVS - 1)) begin
              cnt   <= '0;
              shreg <= {s, shreg[7:1]};
              if (bitn == 3'd7) st <= RX_STOP;
              else              bitn <= bitn + 1'b1;
            end else cnt <= cnt + 1'b1;
          end
          RX_STOP: begin
            if (cnt == OCW'(OVS - 1)) begin
              cnt <= '0;
              if (s) begin
                valid <= 1'b1;
                data  <= shreg;
                st    <= RX_IDLE;
              end else st <= RX_BREAK;
            end else cnt <= cnt + 1'b1;
          end
          default: if (s) st <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/midi_uart_port.sv
module midi_uart_port #(
  parameter int CLK_HZ = 8_000_000,
  parameter int BAUD   = 31_250,
  parameter int OVS    = 16,
  parameter int DEPTH  = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_cs,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic [1:0] trig_sel,
  input  logic       midi_in,
  output logic       midi_out,
  output logic       irq
);
  import midi_pkg::*;
  localparam int DIV = (CLK_HZ / (BAUD * OVS) > 0) ? CLK_HZ / (BAUD * OVS) : 1;
  localparam int CW  = $clog2(DEPTH + 1);

  logic          tick;
  logic          wr_data, wr_cmd, rd_data, rd_stat;
  logic          uart_mode, ack_pend, flush;
  logic          tx_take, tx_empty, tx_full;
  logic [7:0]    tx_dout;
  logic [CW-1:0] tx_cnt;
  logic          rx_valid, rx_push;
  logic [7:0]    rx_byte, rx_din, rx_dout;
  logic          rx_empty, rx_full;
  logic [CW-1:0] rx_cnt, trig_q;

  assign wr_data = bus_cs && bus_wr && !bus_addr;
  assign wr_cmd  = bus_cs && bus_wr &&  bus_addr;
  assign rd_data = bus_cs && bus_rd && !bus_addr;
  assign rd_stat = bus_cs && bus_rd &&  bus_addr;
  assign flush   = wr_cmd && (bus_wdata == CMD_RESET);
  assign rx_push = ack_pend || (rx_valid && uart_mode);
  assign rx_din  = ack_pend ? ACK_BYTE : rx_byte;
  assign trig_q  = CW'(trig_level(trig_sel, DEPTH));

  always_ff @(posedge clk) begin
    if (rst) begin
      uart_mode <= 1'b0;
      ack_pend  <= 1'b0;
    end else begin
      ack_pend <= flush;
      if (flush)                                     uart_mode <= 1'b0;
      else if (wr_cmd && bus_wdata == CMD_UART)      uart_mode <= 1'b1;
    end
  end

  midi_tick_gen #(.DIV(DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  midi_fifo #(.W(8), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .clr(flush),
    .push(wr_data && uart_mode), .din(bus_wdata),
    .pop(tx_take), .dout(tx_dout),
    .empty(tx_empty), .full(tx_full), .count(tx_cnt));

  midi_tx #(.OVS(OVS)) u_tx (
    .clk(clk), .rst(rst), .abort(flush), .tick(tick),
    .have_data(!tx_empty), .data(tx_dout), .take(tx_take), .line(midi_out));

  midi_rx #(.OVS(OVS)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .line_in(midi_in),
    .valid(rx_valid), .data(rx_byte));

  midi_fifo #(.W(8), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .clr(flush),
    .push(rx_push), .din(rx_din),
    .pop(rd_data), .dout(rx_dout),
    .empty(rx_empty), .full(rx_full), .count(rx_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= (rx_cnt >= trig_q);
      if (rd_data) begin
        bus_rdata <= rx_empty ? 8'h00 : rx_dout;
      end else if (rd_stat) begin
        bus_rdata <= '0;
        bus_rdata[STAT_RX_EMPTY] <= rx_empty;
        bus_rdata[STAT_TX_FULL]  <= tx_full;
      end
    end
  end

  assert_irq_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(rx_cnt) != '0));
  assert_reset_ack_R6: assert property (@(posedge clk) disable iff (rst)
    flush |=> ##1 (rx_cnt == CW'(1)));
  assert_rx_gate_R7: assert property (@(posedge clk) disable iff (rst)
    (!uart_mode && !ack_pend) |=> (rx_cnt <= $past(rx_cnt)));
  assert_tx_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !uart_mode |=> (tx_cnt <= $past(tx_cnt)));
  assert_rx_drop_R10: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rd_data && !flush) |=> rx_full);
endmodule

// File: tb/sim_midi_uart_port.sv
module sim_midi_uart_port;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ     = 1_000_000;
  localparam int BAUD       = 31_250;
  localparam int BITC       = CLK_HZ / BAUD;

  logic       clk = 1'b0, rst = 1'b1;
  logic       bus_cs = 0, bus_wr = 0, bus_rd = 0, bus_addr = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [1:0] trig_sel = 2'b00;
  logic       midi_in = 1'b1, midi_out, irq;
  int         total = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  midi_uart_port #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) u0 (
    .clk(clk), .rst(rst), .bus_cs(bus_cs), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .trig_sel(trig_sel), .midi_in(midi_in), .midi_out(midi_out), .irq(irq));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bwrite(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_cs = 0; bus_wr = 0;
  endtask

  task automatic bread(input logic a, output logic [7:0] d);
    @(negedge clk);
    bus_cs = 1; bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_cs = 0; bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic send_ser(input logic [7:0] b, input logic stopv);
    @(negedge clk);
    midi_in = 1'b0; cyc(BITC);
    for (int i = 0; i < 8; i++) begin midi_in = b[i]; cyc(BITC); end
    midi_in = stopv; cyc(BITC);
    midi_in = 1'b1; cyc(BITC);
  endtask

  task automatic grab_tx(output logic [7:0] b, output logic stopv);
    int w = 0;
    b = 8'h00; stopv = 1'b0;
    while (midi_out === 1'b1 && w < 4000) begin @(negedge clk); w++; end
    if (w >= 4000) return;
    cyc(BITC/2);
    for (int i = 0; i < 8; i++) begin cyc(BITC); b[i] = midi_out; end
    cyc(BITC); stopv = midi_out;
  endtask

  task automatic watch_high(input string tag, input int n);
    logic seen_low = 1'b0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (midi_out !== 1'b1) seen_low = 1'b1; end
    chk(tag, {7'd0, seen_low}, 8'h00);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R13 midi_out", {7'd0, midi_out}, 8'h01);
    chk("R13 irq", {7'd0, irq}, 8'h00);
    bread(1, d); chk("R13 status", d, 8'h80);
  endtask

  task automatic t_gated;
    logic [7:0] d;
    bwrite(0, 8'h55);
    watch_high("R7 no tx before uart mode", 3*BITC);
    send_ser(8'h12, 1'b1);
    bread(1, d); chk("R7 rx not stored before uart mode", d, 8'h80);
  endtask

  task automatic t_ack;
    logic [7:0] d;
    bwrite(1, 8'hFF); cyc(2);
    bread(1, d); chk("R6 ack present", d, 8'h00);
    bread(0, d); chk("R6 ack byte", d, 8'hFE);
    bread(1, d); chk("R6 after ack", d, 8'h80);
    bwrite(1, 8'h3F);
  endtask

  task automatic t_tx;
    logic [7:0] b; logic sb;
    bwrite(0, 8'hA5);
    grab_tx(b, sb);
    chk("R1 tx byte", b, 8'hA5);
    chk("R1 stop bit", {7'd0, sb}, 8'h01);
    bwrite(0, 8'h01); bwrite(0, 8'h80); bwrite(0, 8'h3C);
    grab_tx(b, sb); chk("R2 order 0", b, 8'h01);
    grab_tx(b, sb); chk("R2 order 1", b, 8'h80);
    grab_tx(b, sb); chk("R2 order 2", b, 8'h3C);
  endtask

  task automatic t_rx;
    logic [7:0] d;
    send_ser(8'h5A, 1'b1); send_ser(8'hC3, 1'b1);
    bread(0, d); chk("R3 rx first", d, 8'h5A);
    bread(0, d); chk("R3 rx second", d, 8'hC3);
    bread(0, d); chk("R12 empty read", d, 8'h00);
    bread(1, d); chk("R12 status after empty read", d, 8'h80);
  endtask

  task automatic t_irq;
    logic [7:0] d;
    trig_sel = 2'b01;
    for (int i = 0; i < 3; i++) send_ser(8'(8'h40 + i), 1'b1);
    chk("R5 below 4", {7'd0, irq}, 8'h00);
    trig_sel = 2'b00; cyc(2);
    chk("R5 level 1", {7'd0, irq}, 8'h01);
    trig_sel = 2'b01;
    send_ser(8'h43, 1'b1);
    chk("R5 at 4", {7'd0, irq}, 8'h01);
    bread(0, d); cyc(2);
    chk("R5 drop below 4", {7'd0, irq}, 8'h00);
    for (int i = 0; i < 3; i++) bread(0, d);
    chk("R5 last byte", d, 8'h43);
  endtask

  task automatic t_framing;
    logic [7:0] d;
    send_ser(8'h77, 1'b0);
    cyc(BITC);
    bread(1, d); chk("R9 bad stop discarded", d, 8'h80);
    send_ser(8'h11, 1'b1);
    bread(0, d); chk("R9 recovery byte", d, 8'h11);
    @(negedge clk); midi_in = 1'b0; cyc(BITC/4); midi_in = 1'b1; cyc(3*BITC);
    bread(1, d); chk("R11 glitch ignored", d, 8'h80);
  endtask

  task automatic t_full;
    logic [7:0] d;
    trig_sel = 2'b11;
    for (int i = 0; i < 13; i++) send_ser(8'(8'h20 + i), 1'b1);
    chk("R5 below 14", {7'd0, irq}, 8'h00);
    send_ser(8'h2D, 1'b1);
    chk("R5 at 14", {7'd0, irq}, 8'h01);
    send_ser(8'h2E, 1'b1); send_ser(8'h2F, 1'b1);
    send_ser(8'hEE, 1'b1);
    for (int i = 0; i < 16; i++) begin
      bread(0, d); chk($sformatf("R10 kept entry %0d", i), d, 8'(8'h20 + i));
    end
    bread(1, d); chk("R10 overflow byte dropped", d, 8'h80);
    trig_sel = 2'b00;
  endtask

  task automatic t_txfull_flush;
    logic [7:0] d, b; logic sb;
    for (int i = 0; i < 17; i++) bwrite(0, 8'(8'h60 + i));
    bread(1, d); chk("R4 tx full flag", d, 8'hC0);
    bwrite(1, 8'hFF); cyc(3);
    chk("R6 line high after abort", {7'd0, midi_out}, 8'h01);
    bread(1, d); chk("R6 flags after flush", d, 8'h00);
    bread(0, d); chk("R6 ack after flush", d, 8'hFE);
    bwrite(0, 8'h99);
    watch_high("R6 tx flushed and gated", 3*BITC);
    bwrite(1, 8'h3F);
    bwrite(0, 8'h42);
    grab_tx(b, sb); chk("R6 first after re-entry", b, 8'h42);
  endtask

  task automatic t_other_cmd;
    logic [7:0] d, b; logic sb;
    bwrite(1, 8'h80); cyc(2);
    bread(1, d); chk("R8 no ack from other cmd", d, 8'h80);
    bwrite(0, 8'h66);
    grab_tx(b, sb); chk("R8 still uart mode", b, 8'h66);
  endtask

  initial begin
    repeat (190_000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    cyc(4); rst = 1'b0; cyc(2);
    t_reset();
    t_gated();
    t_ack();
    t_tx();
    t_rx();
    t_irq();
    t_framing();
    t_full();
    t_txfull_flush();
    t_other_cmd();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule